// File: doc/BRIEF.md
# I2C Bus Phase Timing Generator

This block generates the SCL waveform for an I2C master, together with the timing strobes the master needs in each bus phase. A sequencer outside the block asks for one phase at a time with a valid/ready handshake. The phases are start setup, start hold, stop setup, repeated-start release, and one full data bit. For each phase the block drives the open-drain SCL pull-down, opens a window in which SDA may change, and raises a one-cycle done pulse when the phase ends. Arbitration and byte sequencing belong to the sequencer, not to this block.

All timing is counted in prescaled ticks from one shared prescaler. A count of N lasts N+1 ticks, and every phase has its own count. The counts come from four packed timing words and one mode word, at fixed bit positions that software packs. The returning SCL line passes through a synchronizer and a programmable glitch filter. The high half of a bit is counted only once the filtered line reads high, so a slave that stretches the clock lengthens the bit. A sequencer that issues bits back to back gets a bit period, in clock cycles, of (div+1)·(low+high+2) + 8 + 2·filter. The words must be held steady while a phase runs.

Top module: `i2c_phase_timer`

## Requirements
- R1: For back-to-back unstretched bits, the time between successive SCL releases (falling edges of `scl_drive_low`) is exactly (div+1)·(low+high+2) + 8 + 2·filter clock cycles.
- R2: A bit phase (code 4) has four parts, in this order:
  - SCL is driven low for (low+1)·(div+1) cycles.
  - SCL is released, and the block waits for the filtered line to read high. With no stretching this wait takes 4+filter cycles.
  - The high count runs for (high+1)·(div+1) cycles.
  - SCL is driven low again, and the block waits 4+filter cycles for the filtered line to read low.
- R3: Codes 0 (start setup), 1 (start hold), 2 (stop setup) and 3 (repeated-start release) each release SCL for (N+1)·(div+1) cycles, where N is the count for that phase.
- R4: `sda_chg_en` is high only during the low part of a bit, and only in tick t (counted from 0 at the start of the low part) with t > hold and t + setup < low. It is low at all other times.
- R5: Each extra cycle that a slave holds SCL low after release lengthens the bit by exactly one cycle. The high count does not begin until the filtered line reads high.
- R6: The filter passes a new line level only after it has been seen on filter+1 consecutive synchronized samples. A shorter pulse has no effect on timing.
- R7: `phase_done` is high for one cycle, in the last cycle of each phase. `req_ready` is high when the block is idle or in a done cycle, so a new request can follow with no gap.
- R8: Request codes 5 to 7 are ignored. No phase starts, no done pulse occurs, and the outputs stay as they were.
- R9: After reset, `scl_drive_low` is 0, `sda_chg_en` is 0, `phase_done` is 0 and `req_ready` is 1.
- R10: The fields sit at these bit positions, and all other bits of the words are ignored:

  | Word | Bits | Field |
  |------|------|-------|
  | `tim_a` | [31:24] | start setup |
  | `tim_a` | [23:16] | start hold |
  | `tim_a` | [15:8] | stop setup |
  | `tim_b` | [31:24] | data setup |
  | `tim_b` | [15:8] | low count |
  | `tim_b` | [7:0] | high count |
  | `tim_c` | [23:16] | prescaler divide |
  | `tim_c` | [7:0] | repeated-start release |
  | `tim_d` | [7:0] | data hold |
  | `mode_word` | [18:16] | filter cycles |

- R11: Between phases `scl_drive_low` keeps its last value: it stays low after a bit and stays released after the other phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Phase request valid |
| req_phase | input | 3 | Phase code: 0 start setup, 1 start hold, 2 stop setup, 3 repeated-start release, 4 bit |
| req_ready | output | 1 | Request accepted in this cycle when high |
| tim_a | input | 32 | Timing word with the start and stop counts |
| tim_b | input | 32 | Timing word with data setup, low and high counts |
| tim_c | input | 32 | Timing word with the prescaler divide and repeated-start release |
| tim_d | input | 32 | Timing word with the data hold count |
| mode_word | input | 32 | Mode word with the filter cycle count |
| scl_in | input | 1 | SCL line as seen on the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_chg_en | output | 1 | SDA may change in this cycle |
| phase_done | output | 1 | One-cycle pulse at the end of a phase |

## Verification
The block is run under three configurations, which differ in:
- prescaler divide: 0, 1 and 3;
- filter: 0, 2 and 7 cycles;
- data-window bounds: one window of two ticks, one that starts at tick 1, and one that is empty.

Bits run back to back and with idle gaps, so the measured period can be matched against the formula and shown to hold independently of the handshake. Each configuration also includes a bit stretched by a slave, which separates the filter delay from the stretch time. A stretch with a one-sample glitch inside it, under a nonzero filter, must leave the period exactly at base plus stretch; a filter that passes short pulses fails this. The unused bits of the words hold non-zero values and an invalid code is issued, so a wrong field position or a wrongly accepted request changes the waveform.

// File: rtl/i2c_phase_pkg.sv
package i2c_phase_pkg;

   localparam int CNT_W  = 8;
   localparam int FILT_W = 3;

   typedef enum logic [2:0] {
      PH_START_SU = 3'd0,
      PH_START_HD = 3'd1,
      PH_STOP_SU  = 3'd2,
      PH_RS_REL   = 3'd3,
      PH_BIT      = 3'd4
   } phase_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HOLD,
      ST_LOW,
      ST_REL,
      ST_HIGH,
      ST_FALL
   } state_e;

   typedef struct packed {
      logic [CNT_W-1:0]  start_su;
      logic [CNT_W-1:0]  start_hd;
      logic [CNT_W-1:0]  stop_su;
      logic [CNT_W-1:0]  data_su;
      logic [CNT_W-1:0]  low;
      logic [CNT_W-1:0]  high;
      logic [CNT_W-1:0]  div;
      logic [CNT_W-1:0]  rs_rel;
      logic [CNT_W-1:0]  hold;
      logic [FILT_W-1:0] filt;
   } timing_t;

   // Field positions are fixed by the software that packs the words (R10).
   function automatic timing_t unpack_timing(input logic [31:0] wa,
                                             input logic [31:0] wb,
                                             input logic [31:0] wc,
                                             input logic [31:0] wd,
                                             input logic [31:0] wm);
      timing_t t;
      t.start_su = wa[24 +: CNT_W];
      t.start_hd = wa[16 +: CNT_W];
      t.stop_su  = wa[8 +: CNT_W];
      t.data_su  = wb[24 +: CNT_W];
      t.low      = wb[8 +: CNT_W];
      t.high     = wb[0 +: CNT_W];
      t.div      = wc[16 +: CNT_W];
      t.rs_rel   = wc[0 +: CNT_W];
      t.hold     = wd[0 +: CNT_W];
      t.filt     = wm[16 +: FILT_W];
      return t;
   endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_W      = 3,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_in,
   input  logic [FILT_W-1:0] filt_len,
   output logic              line_q
);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("line filter needs two or more sync stages");
      assert (FILT_W >= 1) else $error("filter count width must be positive");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   samp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b1;
      else        sync_q[0] <= line_in;
   end

   for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[i] <= 1'b1;
         else        sync_q[i] <= sync_q[i-1];
      end
   end

   assign samp = sync_q[SYNC_STAGES-1];

   if (FILTER_EN) begin : g_filter
      logic [FILT_W-1:0] run_q;
      logic              filt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            filt_q <= 1'b1;
            run_q  <= '0;
         end else if (samp == filt_q) begin
            run_q <= '0;
         end else if (run_q == filt_len) begin
            filt_q <= samp;
            run_q  <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end

      assign line_q = filt_q;

      // R6: a new filtered level is only ever one the synchronizer just showed
      a_r6_commit_matches_sample: assert property (@(posedge clk) disable iff (!rst_n)
         (filt_q != $past(filt_q)) |-> ($past(samp) == filt_q));
   end else begin : g_bypass
      logic unused_filt_len;
      assign unused_filt_len = ^filt_len;
      assign line_q = samp;
   end

endmodule

// File: rtl/i2c_seg_timer.sv
module i2c_seg_timer #(
   parameter int DIV_W = 8,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] tick_idx,
   output logic             seg_last
);

   initial begin
      assert (DIV_W >= 1 && CNT_W >= 1) else $error("timer widths must be positive");
   end

   logic [DIV_W-1:0] pre_q;
   logic             pre_wrap;

   assign pre_wrap = (pre_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q    <= '0;
         tick_idx <= '0;
      end else if (clr) begin
         pre_q    <= '0;
         tick_idx <= '0;
      end else if (run) begin
         if (pre_wrap) begin
            pre_q    <= '0;
            tick_idx <= tick_idx + 1'b1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   assign seg_last = run && pre_wrap && (tick_idx == limit);

   // R2: a running segment never counts past its programmed length
   a_r2_tick_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (tick_idx <= limit));

endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer
   import i2c_phase_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [2:0]  req_phase,
   output logic        req_ready,
   input  logic [31:0] tim_a,
   input  logic [31:0] tim_b,
   input  logic [31:0] tim_c,
   input  logic [31:0] tim_d,
   input  logic [31:0] mode_word,
   input  logic        scl_in,
   output logic        scl_drive_low,
   output logic        sda_chg_en,
   output logic        phase_done
);

   localparam int SUM_W = CNT_W + 1;

   timing_t          cfg;
   state_e           st_q, st_d;
   phase_e           ph_q;
   logic             line_q;
   logic             counting, seg_last, accept, code_ok;
   logic [CNT_W-1:0] seg_limit, tick_idx;
   logic [SUM_W-1:0] setup_end;
   logic             unused_words;

   assign cfg = unpack_timing(tim_a, tim_b, tim_c, tim_d, mode_word);
   assign unused_words = ^{tim_a[7:0], tim_b[23:16], tim_c[31:24], tim_c[15:8],
                           tim_d[31:8], mode_word[31:19], mode_word[15:0]};

   i2c_line_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_W      (FILT_W),
      .FILTER_EN   (FILTER_EN)
   ) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (scl_in),
      .filt_len (cfg.filt),
      .line_q   (line_q)
   );

   assign counting = (st_q == ST_HOLD) || (st_q == ST_LOW) || (st_q == ST_HIGH);

   always_comb begin
      unique case (st_q)
         ST_LOW:  seg_limit = cfg.low;
         ST_HIGH: seg_limit = cfg.high;
         default: begin
            unique case (ph_q)
               PH_START_SU: seg_limit = cfg.start_su;
               PH_START_HD: seg_limit = cfg.start_hd;
               PH_STOP_SU:  seg_limit = cfg.stop_su;
               default:     seg_limit = cfg.rs_rel;
            endcase
         end
      endcase
   end

   i2c_seg_timer #(
      .DIV_W (CNT_W),
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!counting || seg_last),
      .run      (counting),
      .div      (cfg.div),
      .limit    (seg_limit),
      .tick_idx (tick_idx),
      .seg_last (seg_last)
   );

   assign phase_done = ((st_q == ST_HOLD) && seg_last) || ((st_q == ST_FALL) && !line_q);
   assign req_ready  = (st_q == ST_IDLE) || phase_done;
   assign code_ok    = (req_phase <= 3'd4);
   assign accept     = req_valid && req_ready && code_ok;

   always_comb begin
      st_d = st_q;
      if (accept) begin
         st_d = (phase_e'(req_phase) == PH_BIT) ? ST_LOW : ST_HOLD;
      end else if (phase_done) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_LOW:  if (seg_last) st_d = ST_REL;
            ST_REL:  if (line_q)   st_d = ST_HIGH;
            ST_HIGH: if (seg_last) st_d = ST_FALL;
            default: st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= ST_IDLE;
         ph_q          <= PH_START_SU;
         scl_drive_low <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept) ph_q <= phase_e'(req_phase);
         unique case (st_d)
            ST_LOW, ST_FALL:         scl_drive_low <= 1'b1;
            ST_REL, ST_HIGH, ST_HOLD: scl_drive_low <= 1'b0;
            default:                 scl_drive_low <= scl_drive_low;
         endcase
      end
   end

   assign setup_end  = {1'b0, tick_idx} + {1'b0, cfg.data_su};
   assign sda_chg_en = (st_q == ST_LOW) && (tick_idx > cfg.hold) &&
                       (setup_end < {1'b0, cfg.low});

   // R4: SDA is only opened while this block holds SCL low
   a_r4_sda_only_low: assert property (@(posedge clk) disable iff (!rst_n)
      sda_chg_en |-> scl_drive_low);

   // R5: the high count begins only after the filtered line read high
   a_r5_high_after_line: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_HIGH) && ($past(st_q) == ST_REL)) |-> $past(line_q));

   // R8: an out-of-range code leaves an idle block idle
   a_r8_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_IDLE) && req_valid && (req_phase > 3'd4)) |=> (st_q == ST_IDLE));

   // R11: the pull-down holds its level across idle cycles
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_IDLE) && ($past(st_q) == ST_IDLE)) |-> $stable(scl_drive_low));

endmodule

// File: tb/i2c_phase_timer_bench.sv
module i2c_phase_timer_bench;

   localparam int CLK_PERIOD   = 10;
   localparam int WATCHDOG_CYC = 60000;

   typedef struct packed {
      logic       drv;
      logic       sda;
      logic       done;
      logic       ext;
      logic [3:0] tag;
   } ent_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_phase = 3'd0;
   logic        req_ready;
   logic [31:0] tim_a = '0, tim_b = '0, tim_c = '0, tim_d = '0, mode_word = '0;
   logic        ext_low = 1'b0;
   logic        scl_line;
   logic        scl_drive_low, sda_chg_en, phase_done;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign scl_line = ~(scl_drive_low | ext_low);

   i2c_phase_timer u_i2c_phase_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_phase     (req_phase),
      .req_ready     (req_ready),
      .tim_a         (tim_a),
      .tim_b         (tim_b),
      .tim_c         (tim_c),
      .tim_d         (tim_d),
      .mode_word     (mode_word),
      .scl_in        (scl_line),
      .scl_drive_low (scl_drive_low),
      .sda_chg_en    (sda_chg_en),
      .phase_done    (phase_done)
   );

   int   checks = 0, errors = 0, cyc = 0;
   ent_t expq[$];
   int   fe_cyc[$];
   logic exp_hold = 1'b0;
   logic prev_drv = 1'b0;
   logic [3:0] idle_tag = 4'd9;
   int   c_div, c_low, c_high, c_su, c_hold, c_f, c_ssu, c_shd, c_psu, c_rs;
   bit   pend_valid = 0;
   int   pend_code, pend_s, pend_j;
   logic [3:0] pend_tag;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // Packs the fields at their documented positions, with junk in every unused bit (R10).
   task automatic apply_cfg();
      tim_a     = {c_ssu[7:0], c_shd[7:0], c_psu[7:0], 8'h96};
      tim_b     = {c_su[7:0], 8'h5A, c_low[7:0], c_high[7:0]};
      tim_c     = {8'hC3, c_div[7:0], 8'h3C, c_rs[7:0]};
      tim_d     = {24'hA5F00F, c_hold[7:0]};
      mode_word = {13'h1ABC, c_f[2:0], 16'hBEEF};
   endtask

   // Behavioural expectation for one accepted phase.
   task automatic build(input int code, input int s, input int j, input logic [3:0] tg);
      ent_t tmp[$];
      ent_t x;
      int   n, nlow;
      if (code == 4) begin
         // R2: low part, with the R4 data window per tick
         for (int t = 0; t <= c_low; t++)
            for (int p = 0; p <= c_div; p++)
               tmp.push_back('{drv:1'b1, sda:((t > c_hold) && (t + c_su < c_low)),
                               done:1'b0, ext:1'b0, tag:tg});
         nlow = tmp.size();
         // R5: release waits for the line, stretched by s cycles
         for (int k = 0; k < 4 + c_f + s; k++)
            tmp.push_back('{drv:1'b0, sda:1'b0, done:1'b0, ext:1'b0, tag:tg});
         for (int k = 0; k < (c_high + 1) * (c_div + 1); k++)
            tmp.push_back('{drv:1'b0, sda:1'b0, done:1'b0, ext:1'b0, tag:tg});
         for (int k = 0; k < 4 + c_f; k++)
            tmp.push_back('{drv:1'b1, sda:1'b0, done:(k == 3 + c_f), ext:1'b0, tag:tg});
         if (s > 0) begin
            for (int k = nlow - 1; k <= nlow + s - 1; k++) begin
               x = tmp[k]; x.ext = 1'b1; tmp[k] = x;
            end
            // R6: a single released sample inside the stretch
            if (j >= 0) begin
               x = tmp[nlow + j]; x.ext = 1'b0; tmp[nlow + j] = x;
            end
         end
      end else begin
         // R3: released for the phase's own count
         case (code)
            0:       n = c_ssu;
            1:       n = c_shd;
            2:       n = c_psu;
            default: n = c_rs;
         endcase
         for (int k = 0; k < (n + 1) * (c_div + 1); k++)
            tmp.push_back('{drv:1'b0, sda:1'b0, done:(k == (n + 1) * (c_div + 1) - 1),
                            ext:1'b0, tag:tg});
      end
      foreach (tmp[k]) expq.push_back(tmp[k]);
   endtask

   task automatic step();
      ent_t e;
      bit   was_idle;
      @(negedge clk);
      cyc++;
      was_idle = (expq.size() == 0);
      if (was_idle) e = '{drv:exp_hold, sda:1'b0, done:1'b0, ext:1'b0, tag:idle_tag};
      else          e = expq.pop_front();
      exp_hold = e.drv;
      chk($sformatf("R%0d", e.tag), "scl_drive_low", scl_drive_low, e.drv);
      chk("R4", "sda_chg_en", sda_chg_en, e.sda);
      chk("R7", "phase_done", phase_done, e.done);
      chk("R7", "req_ready", req_ready, (was_idle || e.done));
      if (prev_drv && !scl_drive_low) fe_cyc.push_back(cyc);
      prev_drv = scl_drive_low;
      ext_low = e.ext;
      if (pend_valid && (was_idle || e.done)) begin
         req_valid = 1'b1;
         req_phase = pend_code[2:0];
         if (pend_code <= 4) build(pend_code, pend_s, pend_j, pend_tag);
         pend_valid = 0;
      end else begin
         req_valid = 1'b0;
      end
   endtask

   task automatic do_phase(input int code, input int s, input int j, input logic [3:0] tg);
      pend_valid = 1; pend_code = code; pend_s = s; pend_j = j; pend_tag = tg;
      while (pend_valid) step();
   endtask

   task automatic drain(input int extra);
      while (expq.size() != 0) step();
      for (int k = 0; k < extra; k++) step();
   endtask

   function automatic int period(input int s);
      return (c_div + 1) * (c_low + c_high + 2) + 8 + 2 * c_f + s;
   endfunction

   task automatic check_gap(input string req, input int a, input int b, input int exp);
      if (fe_cyc.size() > b) chk(req, "release-to-release cycles", fe_cyc[b] - fe_cyc[a], exp);
      else chk(req, "release edges seen", fe_cyc.size(), b + 1);
   endtask

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG_CYC);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // Configuration A: prescaler 1, no filter
      c_div = 1; c_low = 5; c_high = 4; c_su = 1; c_hold = 1; c_f = 0;
      c_ssu = 2; c_shd = 1; c_psu = 3; c_rs = 2;
      apply_cfg();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state observed over a few idle cycles
      idle_tag = 4'd9;
      for (int k = 0; k < 3; k++) step();
      idle_tag = 4'd11;
      fe_cyc.delete();
      do_phase(0, 0, -1, 4'd3);
      do_phase(1, 0, -1, 4'd3);
      do_phase(4, 0, -1, 4'd2);
      do_phase(4, 0, -1, 4'd2);
      do_phase(4, 3, -1, 4'd5);
      do_phase(4, 0, -1, 4'd2);
      drain(4);
      // R1: period formula; R5: the stretch adds exactly its length
      check_gap("R1", 0, 1, period(0));
      check_gap("R1", 1, 2, period(0));
      check_gap("R5", 2, 3, period(3));
      // R8: out-of-range code, outputs must stay idle with SCL held low
      idle_tag = 4'd8;
      do_phase(6, 0, -1, 4'd8);
      drain(5);
      idle_tag = 4'd11;
      do_phase(2, 0, -1, 4'd3);
      do_phase(3, 0, -1, 4'd3);
      drain(4);

      // Configuration B: no prescaling, filter 2, glitch inside a stretch
      c_div = 0; c_low = 6; c_high = 2; c_su = 2; c_hold = 0; c_f = 2;
      c_ssu = 1; c_shd = 2; c_psu = 1; c_rs = 4;
      apply_cfg();
      drain(2);
      fe_cyc.delete();
      do_phase(4, 0, -1, 4'd2);
      do_phase(4, 5, 2, 4'd6);
      do_phase(4, 0, -1, 4'd2);
      drain(3);
      check_gap("R1", 0, 1, period(0));
      check_gap("R6", 1, 2, period(5));
      do_phase(3, 0, -1, 4'd3);
      drain(3);

      // Configuration C: prescaler 3, longest filter, empty data window, zero counts
      c_div = 3; c_low = 2; c_high = 1; c_su = 1; c_hold = 1; c_f = 7;
      c_ssu = 0; c_shd = 0; c_psu = 5; c_rs = 0;
      apply_cfg();
      drain(2);
      fe_cyc.delete();
      do_phase(1, 0, -1, 4'd3);
      do_phase(4, 0, -1, 4'd2);
      do_phase(4, 0, -1, 4'd2);
      do_phase(4, 2, -1, 4'd5);
      drain(2);
      check_gap("R1", 0, 1, period(0));
      check_gap("R5", 1, 2, period(0));
      do_phase(2, 0, -1, 4'd3);
      do_phase(0, 0, -1, 4'd3);
      drain(4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule